// File: doc/BRIEF.md
# Cascaded Level Interrupt Aggregator

This block collects up to thirty-two level-type interrupt requests and presents them to a parent interrupt controller as one line. Every source owns a bit in a pending register, where a request is captured, and a bit in an enable register, which decides whether the captured request may reach the parent. The parent line is a registered OR of every bit that is both pending and enabled.

Software reaches the block through a small 32-bit register port with byte offsets. The pending register sits at 0x0. Writing a 1 to one of its bits acknowledges that source, and writing a 0 leaves the bit alone. The enable register sits at 0x4 and is written as a whole word. A read-only dispatch register at 0x8 reports which active source has the lowest number, so a handler can start on that source without scanning bits.

Because the sources are level-type, a request that is still asserted after it is acknowledged captures itself again. The parent's usual flow is to mask the line, service the source, acknowledge it and then unmask. A full shutdown is done by clearing the enable register and then writing all ones to the pending register.

Top module: `irq_gather`

## Requirements
- R1: After reset the pending register (0x0) reads 0, the enable register (0x4) reads 0, the dispatch register (0x8) reads 0 and `irq_out` is low.
- R2: A request input that is high at a clock edge sets its pending bit (bit n for source n) at that edge, whatever the enable bit holds, and the bit stays set after the input drops.
- R3: A write to offset 0x4 replaces the enable register with the written word, and the new value reads back from 0x4.
- R4: Writing a 1 to bit n at offset 0x0 clears pending bit n when source n's request is low. Writing 0 to a bit leaves it unchanged.
- R5: When a request input is high in the same cycle as an acknowledge of its bit, the pending bit stays set. This holds both for a request that was already pending and for a new one.
- R6: `irq_out` equals the OR over all sources of (pending AND enable) as it stood before the previous clock edge. It rises one cycle after a source becomes active and falls one cycle after the last active bit is acknowledged or masked.
- R7: The dispatch register at 0x8 returns bit 31 = 1 and bits [4:0] = the index of the lowest-numbered source whose pending and enable bits are both 1. All other bits are 0, and pending bits that are masked are ignored.
- R8: When no source is active, the dispatch register reads exactly 0, meaning bit 31 is 0 ("none pending").
- R9: With all request inputs low, writing 0 to 0x4 and then 0xFFFFFFFF to 0x0 leaves every source disabled, nothing pending, and `irq_out` low one cycle later.
- R10: Writes to 0x8 or to any unused offset such as 0xC change no register, and a read of an unused offset returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_req | input | NUM_SRC | Level request inputs, one per source |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register (combinational) |
| irq_out | output | 1 | Registered interrupt line to the parent controller |

## Verification
The bench builds the block with the default NUM_SRC of 32. That fills the whole register word and makes the five-bit dispatch index reach its top value of 31. With this build the bench can drive the highest source and the lowest one at the same time, and it can write an all-ones acknowledge that covers every bit. A smaller build would leave the upper pending bits tied to zero and would not reach index 31.

// File: rtl/irqg_pkg.sv
`timescale 1ns/1ps
package irqg_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned ADDR_W = 4;

    localparam logic [ADDR_W-1:0] OFS_PENDING  = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_ENABLE   = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_DISPATCH = 4'h8;

    localparam int unsigned VALID_BIT = WORD_W - 1;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] wdata;
    } reg_req_t;
endpackage

// File: rtl/irqg_pending_bank.sv
`timescale 1ns/1ps
module irqg_pending_bank #(
    parameter int unsigned NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic [NUM_SRC-1:0] ack_i,
    output logic [NUM_SRC-1:0] pend_o
);
    logic [NUM_SRC-1:0] pend_d, pend_q;

    always_comb begin
        // a live request outranks an acknowledge of the same bit
        pend_d = (pend_q & ~ack_i) | req_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign pend_o = pend_q;

    p_req_captured_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i != '0) |=> ((pend_q & $past(req_i)) == $past(req_i)));

    p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i != '0) |=> ((pend_q & $past(ack_i & ~req_i)) == '0));

    p_zero_ack_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i == '0) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));
endmodule

// File: rtl/irqg_enable_reg.sv
`timescale 1ns/1ps
module irqg_enable_reg #(
    parameter int unsigned NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  logic [NUM_SRC-1:0] wdata_i,
    output logic [NUM_SRC-1:0] en_o
);
    logic [NUM_SRC-1:0] en_d, en_q;

    always_comb begin
        en_d = en_q;
        if (wr_i) en_d = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d;
    end

    assign en_o = en_q;

    p_enable_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (en_q == $past(wdata_i)));

    p_enable_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(en_q));
endmodule

// File: rtl/irqg_first_pick.sv
`timescale 1ns/1ps
module irqg_first_pick #(
    parameter int unsigned NUM_SRC = 32,
    localparam int unsigned IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0] active_i,
    output logic               valid_o,
    output logic [IDX_W-1:0]   idx_o
);
    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        // walk downward so the lowest set bit is the last one written
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (active_i[i]) begin
                valid_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_gather.sv
`timescale 1ns/1ps
module irq_gather
    import irqg_pkg::*;
#(
    parameter int unsigned NUM_SRC = 32,
    localparam int unsigned IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [WORD_W-1:0]  bus_wdata,
    output logic [WORD_W-1:0]  bus_rdata,
    output logic               irq_out
);
    typedef struct packed {
        logic irq;
    } line_state_t;

    reg_req_t           req_w;
    logic [NUM_SRC-1:0] ack_w, pend_w, en_w, active_w;
    logic               en_wr_w;
    logic               pick_valid_w;
    logic [IDX_W-1:0]   pick_idx_w;
    line_state_t        st_d, st_q;

    assign req_w = '{wr: bus_wr, addr: bus_addr, wdata: bus_wdata};

    always_comb begin
        ack_w   = '0;
        en_wr_w = 1'b0;
        if (req_w.wr && req_w.addr == OFS_PENDING) ack_w   = req_w.wdata[NUM_SRC-1:0];
        if (req_w.wr && req_w.addr == OFS_ENABLE)  en_wr_w = 1'b1;
    end

    irqg_pending_bank #(.NUM_SRC(NUM_SRC)) u_pending (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (src_req),
        .ack_i  (ack_w),
        .pend_o (pend_w)
    );

    irqg_enable_reg #(.NUM_SRC(NUM_SRC)) u_enable (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (en_wr_w),
        .wdata_i (req_w.wdata[NUM_SRC-1:0]),
        .en_o    (en_w)
    );

    assign active_w = pend_w & en_w;

    irqg_first_pick #(.NUM_SRC(NUM_SRC)) u_pick (
        .active_i (active_w),
        .valid_o  (pick_valid_w),
        .idx_o    (pick_idx_w)
    );

    always_comb begin
        st_d     = st_q;
        st_d.irq = |active_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_out = st_q.irq;

    always_comb begin
        bus_rdata = '0;
        case (req_w.addr)
            OFS_PENDING:  bus_rdata[NUM_SRC-1:0] = pend_w;
            OFS_ENABLE:   bus_rdata[NUM_SRC-1:0] = en_w;
            OFS_DISPATCH: begin
                bus_rdata[VALID_BIT]   = pick_valid_w;
                bus_rdata[IDX_W-1:0]   = pick_idx_w;
            end
            default:      bus_rdata = '0;
        endcase
    end

    // checker view: bits below the reported index
    logic [NUM_SRC-1:0] below_pick_w;
    assign below_pick_w = (NUM_SRC'(1) << pick_idx_w) - NUM_SRC'(1);

    p_line_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_out == $past(|(pend_w & en_w))));

    p_pick_is_lowest_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pick_valid_w |-> (active_w[pick_idx_w] && ((active_w & below_pick_w) == '0)));

    p_none_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !pick_valid_w |-> (active_w == '0));

    p_quiet_when_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (en_w == '0) |=> !irq_out);
endmodule

// File: tb/irq_gather_test.sv
`timescale 1ns/10ps
module irq_gather_test;
    localparam int unsigned NSRC = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] src_req = '0;
    logic            bus_wr = 1'b0;
    logic [3:0]      bus_addr = 4'h0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic            irq_out;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    irq_gather #(.NUM_SRC(NSRC)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_req   (src_req),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    typedef struct {
        string       tag;
        bit          is_line;
        logic [31:0] exp;
    } item_t;

    item_t q[$];
    event  sample_ev;

    // monitor: pops each expected item and compares with the live output
    initial begin
        forever begin
            @(sample_ev);
            while (q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it  = q.pop_front();
                act = it.is_line ? {31'b0, irq_out} : bus_rdata;
                tests++;
                if (act !== it.exp) begin
                    fails++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
        bus_wdata = '0;
    endtask

    task automatic pulse_req(input logic [NSRC-1:0] v);
        src_req = v;
        @(negedge clk);
        src_req = '0;
    endtask

    task automatic check_reg(input logic [3:0] a, input logic [31:0] e, input string tag);
        item_t it;
        bus_addr = a;
        #0.1;
        it.tag = tag; it.is_line = 1'b0; it.exp = e;
        q.push_back(it);
        -> sample_ev;
        #0.1;
    endtask

    task automatic check_line(input logic e, input string tag);
        item_t it;
        #0.1;
        it.tag = tag; it.is_line = 1'b1; it.exp = {31'b0, e};
        q.push_back(it);
        -> sample_ev;
        #0.1;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();

        // R1 reset state
        check_reg(4'h0, 32'h0, "R1 pending after reset");
        check_reg(4'h4, 32'h0, "R1 enable after reset");
        check_reg(4'h8, 32'h0, "R1 dispatch after reset");
        check_line(1'b0, "R1 line after reset");

        // R2 capture while masked, held after input drops
        pulse_req(32'h0000_0020);
        check_reg(4'h0, 32'h0000_0020, "R2 pending bit5 latched");
        check_reg(4'h8, 32'h0, "R8 masked pending gives none");
        step();
        check_line(1'b0, "R6 masked source keeps line low");

        // R3 enable write, R6 rise latency, R7 dispatch
        reg_write(4'h4, 32'h0000_00A0);
        check_reg(4'h4, 32'h0000_00A0, "R3 enable readback");
        check_reg(4'h8, 32'h8000_0005, "R7 lowest active is 5");
        check_line(1'b0, "R6 line not yet up in enable cycle");
        step();
        check_line(1'b1, "R6 line up one cycle later");

        // R2 several sources together
        pulse_req(32'h8000_0080);
        check_reg(4'h0, 32'h8000_00A0, "R2 bits 31 7 5 pending");
        check_reg(4'h8, 32'h8000_0005, "R7 lowest still 5");

        // R4 zero write has no effect
        reg_write(4'h0, 32'h0000_0000);
        check_reg(4'h0, 32'h8000_00A0, "R4 zero write keeps pending");

        // R4 ack bit5
        reg_write(4'h0, 32'h0000_0020);
        check_reg(4'h0, 32'h8000_0080, "R4 ack clears bit5");
        check_reg(4'h8, 32'h8000_0007, "R7 next lowest is 7");
        check_line(1'b1, "R6 line stays with bit7 active");

        // R5 ack while request still high
        src_req = 32'h0000_0080;
        reg_write(4'h0, 32'h0000_0080);
        check_reg(4'h0, 32'h8000_0080, "R5 live request survives ack");
        src_req = '0;
        reg_write(4'h0, 32'h0000_0080);
        check_reg(4'h0, 32'h8000_0000, "R4 ack clears bit7 after drop");
        check_reg(4'h8, 32'h0, "R8 only masked bit31 left");
        check_line(1'b1, "R6 line still high in ack cycle");
        step();
        check_line(1'b0, "R6 line falls one cycle after ack");

        // R7 top index, R6 fall on mask
        reg_write(4'h4, 32'h8000_00A0);
        check_reg(4'h8, 32'h8000_001F, "R7 lowest active is 31");
        check_line(1'b0, "R6 line low in enable cycle");
        step();
        check_line(1'b1, "R6 line up for bit31");
        reg_write(4'h4, 32'h0000_0000);
        check_line(1'b1, "R6 line still high in mask cycle");
        check_reg(4'h8, 32'h0, "R8 none pending after mask");
        step();
        check_line(1'b0, "R6 line falls one cycle after mask");

        // R10 ignored writes
        reg_write(4'h8, 32'hFFFF_FFFF);
        reg_write(4'hC, 32'hFFFF_FFFF);
        check_reg(4'h0, 32'h8000_0000, "R10 pending untouched");
        check_reg(4'h4, 32'h0000_0000, "R10 enable untouched");
        check_reg(4'hC, 32'h0, "R10 unused offset reads zero");
        check_reg(4'h8, 32'h0, "R10 dispatch unchanged");

        // R9 shutdown sequence
        reg_write(4'h4, 32'hFFFF_FFFF);
        pulse_req(32'h0000_0F0F);
        step();
        check_line(1'b1, "R9 line up before shutdown");
        reg_write(4'h4, 32'h0000_0000);
        reg_write(4'h0, 32'hFFFF_FFFF);
        check_reg(4'h0, 32'h0, "R9 nothing pending");
        check_reg(4'h4, 32'h0, "R9 all disabled");
        check_reg(4'h8, 32'h0, "R9 dispatch none");
        check_line(1'b0, "R9 line low");

        // R5 new request and ack in the same cycle
        src_req = 32'h0000_0008;
        reg_write(4'h0, 32'h0000_0008);
        src_req = '0;
        check_reg(4'h0, 32'h0000_0008, "R5 new request beats ack");
        reg_write(4'h0, 32'h0000_0008);
        check_reg(4'h0, 32'h0, "R4 ack clears bit3");

        step();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule